// File: doc/BRIEF.md
# Machine Counter and Identification CSR Unit

This block is the slice of a processor's control and status register file that keeps execution counters and identification values for machine mode. It contains a cycle counter that advances on every clock and a retired-instruction counter that advances on each retire pulse. It also has a counter-inhibit register that can freeze the instruction counter, and four read-only identification registers.

Each cycle the pipeline can present one CSR access. An access carries an enable, a 12-bit address, an operation code, write data and the current privilege level. In the same cycle the block returns three things: the register's value before the access, the value a write would commit, and a flag that marks the access as illegal. The pipeline uses the illegal flag to raise an exception.

Top module: `mctr_csr_unit`

## Requirements
- R1: After the asynchronous active-low reset, the cycle counter, instruction counter and inhibit bit are zero. With `csr_en` low, `csr_rdata`, `csr_wval` and `csr_illegal` are all zero.
- R2: The cycle counter adds one on every clock after reset and wraps modulo 2^XLEN. Reads at 0xC00 and 0xC01 both return it.
- R3: When inhibit bit 2 is clear, the instruction counter adds one on each clock where `retire` is high, and it wraps modulo 2^XLEN.
- R4: While inhibit bit 2 is set, `retire` pulses leave the instruction counter unchanged.
- R5: A legal write to 0xB02 loads the committed value exactly, even if `retire` is high in the same cycle. The next read of 0xB02 or of 0xC02 returns that value.
- R6: The inhibit register at 0x320 keeps only bit 2 of a committed value. All other bits read as zero.
- R7: Operation codes are 0 read, 1 write (new = wdata), 2 set (new = old | wdata) and 3 clear (new = old & ~wdata). `csr_rdata` is the value before the access. `csr_wval` is the value committed, or zero if nothing is written.
- R8: 0xF11, 0xF12 and 0xF13 read as zero, and 0xF14 reads the HART_ID parameter. Any operation other than a read on these four addresses is illegal.
- R9: Privilege encoding is 3 machine, 1 supervisor, 0 user. Any access to 0x320, 0xB02 or 0xF11–0xF14 at a privilege other than 3 is illegal.
- R10: 0xC00, 0xC01 and 0xC02 can be read at any privilege. Any operation other than a read on them is illegal.
- R11: Accesses to any other address are illegal. An illegal access changes no state and drives `csr_rdata` and `csr_wval` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_en | input | 1 | Access present this cycle |
| csr_op | input | 2 | Operation code (R7) |
| csr_addr | input | 12 | CSR address |
| csr_priv | input | 2 | Current privilege level |
| csr_wdata | input | XLEN | Write/set/clear operand |
| retire | input | 1 | One instruction retired this cycle |
| csr_rdata | output | XLEN | Value before the access |
| csr_wval | output | XLEN | Value committed by a write |
| csr_illegal | output | 1 | Access rejected |

## Verification
The bench builds the block with XLEN set to 16 and HART_ID set to 5. At that width a counter wrap can be reached directly: the bench loads 0xFFFF and then retires one instruction. The cycle counter also passes through a full 16-bit period during the random phase, so wrapping is checked on both counters. A non-zero HART_ID shows that 0xF14 is decoded separately from the three identification registers that read as zero.

// File: rtl/mctr_pkg.sv
package mctr_pkg;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_SET   = 2'd2,
    OP_CLEAR = 2'd3
  } csr_op_e;

  localparam logic [1:0] PRIV_U = 2'd0;
  localparam logic [1:0] PRIV_S = 2'd1;
  localparam logic [1:0] PRIV_M = 2'd3;

  localparam logic [11:0] ADR_UCYC   = 12'hC00;
  localparam logic [11:0] ADR_UTIME  = 12'hC01;
  localparam logic [11:0] ADR_UINST  = 12'hC02;
  localparam logic [11:0] ADR_INHIB  = 12'h320;
  localparam logic [11:0] ADR_MINST  = 12'hB02;
  localparam logic [11:0] ADR_ID0    = 12'hF11;
  localparam logic [11:0] ADR_ID1    = 12'hF12;
  localparam logic [11:0] ADR_ID2    = 12'hF13;
  localparam logic [11:0] ADR_HART   = 12'hF14;

  typedef struct packed {
    logic cyc;
    logic ins;
    logic inh;
    logic idz;
    logic hart;
  } csr_sel_t;

endpackage

// File: rtl/mctr_decode.sv
module mctr_decode
  import mctr_pkg::*;
(
  input  logic        en,
  input  logic [11:0] addr,
  input  logic [1:0]  op,
  input  logic [1:0]  priv,
  output csr_sel_t    sel,
  output logic        illegal,
  output logic        wr_en
);

  csr_sel_t raw;
  logic     hit;
  logic     m_only;
  logic     ro;
  logic     is_wr;

  always_comb begin
    raw    = '0;
    hit    = 1'b1;
    m_only = 1'b0;
    ro     = 1'b0;
    case (addr)
      ADR_UCYC, ADR_UTIME: begin
        raw.cyc = 1'b1;
        ro      = 1'b1;
      end
      ADR_UINST: begin
        raw.ins = 1'b1;
        ro      = 1'b1;
      end
      ADR_INHIB: begin
        raw.inh = 1'b1;
        m_only  = 1'b1;
      end
      ADR_MINST: begin
        raw.ins = 1'b1;
        m_only  = 1'b1;
      end
      ADR_ID0, ADR_ID1, ADR_ID2: begin
        raw.idz = 1'b1;
        m_only  = 1'b1;
        ro      = 1'b1;
      end
      ADR_HART: begin
        raw.hart = 1'b1;
        m_only   = 1'b1;
        ro       = 1'b1;
      end
      default: hit = 1'b0;
    endcase
  end

  always_comb begin
    is_wr   = (csr_op_e'(op) != OP_READ);
    illegal = en & (~hit | (m_only & (priv != PRIV_M)) | (ro & is_wr));
    sel     = (en & ~illegal) ? raw : '0;
    wr_en   = en & ~illegal & is_wr;
  end

endmodule

// File: rtl/mctr_rmw.sv
module mctr_rmw
  import mctr_pkg::*;
#(
  parameter int W = 64
) (
  input  logic [1:0]   op,
  input  logic [W-1:0] old_val,
  input  logic [W-1:0] operand,
  output logic [W-1:0] new_val
);

  always_comb begin
    case (csr_op_e'(op))
      OP_WRITE: new_val = operand;
      OP_SET:   new_val = old_val | operand;
      OP_CLEAR: new_val = old_val & ~operand;
      default:  new_val = old_val;
    endcase
  end

endmodule

// File: rtl/mctr_counter.sv
module mctr_counter #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] q
);

  logic [W-1:0] q_d;
  logic         q_ce;

  always_comb begin
    q_ce = ld | inc;
    q_d  = ld ? ld_val : q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (q_ce) begin
      q <= q_d;
    end
  end

endmodule

// File: rtl/mctr_csr_unit.sv
module mctr_csr_unit
  import mctr_pkg::*;
#(
  parameter int          XLEN    = 64,
  parameter int unsigned HART_ID = 0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            csr_en,
  input  logic [1:0]      csr_op,
  input  logic [11:0]     csr_addr,
  input  logic [1:0]      csr_priv,
  input  logic [XLEN-1:0] csr_wdata,
  input  logic            retire,
  output logic [XLEN-1:0] csr_rdata,
  output logic [XLEN-1:0] csr_wval,
  output logic            csr_illegal
);

  localparam int              IR_BIT   = 2;
  localparam logic [XLEN-1:0] INH_MASK = XLEN'(1) << IR_BIT;
  localparam logic [XLEN-1:0] HART_VAL = XLEN'(HART_ID);

  csr_sel_t        sel;
  logic            wr_en;
  logic [XLEN-1:0] cycle_q;
  logic [XLEN-1:0] instret_q;
  logic            inh_bit;
  logic            inh_d;
  logic            inh_ce;
  logic [XLEN-1:0] inh_view;
  logic [XLEN-1:0] old_val;
  logic [XLEN-1:0] rmw_val;
  logic [XLEN-1:0] commit_val;
  logic            ins_ld;
  logic            ins_inc;

  mctr_decode u_decode (
    .en      (csr_en),
    .addr    (csr_addr),
    .op      (csr_op),
    .priv    (csr_priv),
    .sel     (sel),
    .illegal (csr_illegal),
    .wr_en   (wr_en)
  );

  always_comb begin
    inh_view         = '0;
    inh_view[IR_BIT] = inh_bit;
    old_val = ({XLEN{sel.cyc}}  & cycle_q)
            | ({XLEN{sel.ins}}  & instret_q)
            | ({XLEN{sel.inh}}  & inh_view)
            | ({XLEN{sel.hart}} & HART_VAL);
  end

  mctr_rmw #(.W(XLEN)) u_rmw (
    .op      (csr_op),
    .old_val (old_val),
    .operand (csr_wdata),
    .new_val (rmw_val)
  );

  always_comb begin
    commit_val  = sel.inh ? (rmw_val & INH_MASK) : rmw_val;
    csr_rdata   = old_val;
    csr_wval    = wr_en ? commit_val : '0;
    ins_ld      = wr_en & sel.ins;
    ins_inc     = retire & ~inh_bit;
    inh_ce      = wr_en & sel.inh;
    inh_d       = commit_val[IR_BIT];
  end

  mctr_counter #(.W(XLEN)) u_cycle (
    .clk    (clk),
    .rst_n  (rst_n),
    .inc    (1'b1),
    .ld     (1'b0),
    .ld_val ('0),
    .q      (cycle_q)
  );

  mctr_counter #(.W(XLEN)) u_instret (
    .clk    (clk),
    .rst_n  (rst_n),
    .inc    (ins_inc),
    .ld     (ins_ld),
    .ld_val (commit_val),
    .q      (instret_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inh_bit <= 1'b0;
    end else if (inh_ce) begin
      inh_bit <= inh_d;
    end
  end

endmodule

// File: rtl/mctr_csr_chk.sv
module mctr_csr_chk #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            csr_en,
  input logic [1:0]      csr_op,
  input logic [11:0]     csr_addr,
  input logic [1:0]      csr_priv,
  input logic            retire,
  input logic [XLEN-1:0] csr_rdata,
  input logic [XLEN-1:0] csr_wval,
  input logic            csr_illegal,
  input logic [XLEN-1:0] cycle_q,
  input logic [XLEN-1:0] instret_q,
  input logic            inh_bit
);

  localparam logic [XLEN-1:0] KEEP = XLEN'(4);

  logic ld_ins;
  logic id_addr;
  assign ld_ins  = csr_en && !csr_illegal && (csr_op != 2'd0) && (csr_addr == 12'hB02);
  assign id_addr = (csr_addr >= 12'hF11) && (csr_addr <= 12'hF14);

  p_cycle_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> cycle_q == $past(cycle_q) + XLEN'(1));

  p_retire_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (retire && !inh_bit && !ld_ins) |=> instret_q == $past(instret_q) + XLEN'(1));

  p_inhibit_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (inh_bit && !ld_ins) |=> $stable(instret_q));

  p_load_exact_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ld_ins |=> instret_q == $past(csr_wval));

  p_inh_bits_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_en && !csr_illegal && csr_addr == 12'h320) |-> ((csr_rdata & ~KEEP) == '0));

  p_id_readonly_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_en && id_addr && csr_op != 2'd0) |-> csr_illegal);

  p_mach_priv_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_en && (id_addr || csr_addr == 12'h320 || csr_addr == 12'hB02) && csr_priv != 2'd3)
      |-> csr_illegal);

  p_illegal_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    csr_illegal |-> (csr_rdata == '0 && csr_wval == '0));

  p_illegal_keep_r11: assert property (@(posedge clk) disable iff (!rst_n)
    csr_illegal |=> $stable(inh_bit));

endmodule

bind mctr_csr_unit mctr_csr_chk #(.XLEN(XLEN)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .csr_en      (csr_en),
  .csr_op      (csr_op),
  .csr_addr    (csr_addr),
  .csr_priv    (csr_priv),
  .retire      (retire),
  .csr_rdata   (csr_rdata),
  .csr_wval    (csr_wval),
  .csr_illegal (csr_illegal),
  .cycle_q     (cycle_q),
  .instret_q   (instret_q),
  .inh_bit     (inh_bit)
);

// File: tb/mctr_csr_unit_tb.sv
module mctr_csr_unit_tb;

  localparam int W        = 16;
  localparam int HART     = 5;
  localparam int CLK_HALF = 5;

  logic         clk;
  logic         rst_n;
  logic         csr_en;
  logic [1:0]   csr_op;
  logic [11:0]  csr_addr;
  logic [1:0]   csr_priv;
  logic [W-1:0] csr_wdata;
  logic         retire;
  logic [W-1:0] csr_rdata;
  logic [W-1:0] csr_wval;
  logic         csr_illegal;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [W-1:0] m_cycle;
  logic [W-1:0] m_inst;
  logic         m_inh;

  mctr_csr_unit #(.XLEN(W), .HART_ID(HART)) u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .csr_en      (csr_en),
    .csr_op      (csr_op),
    .csr_addr    (csr_addr),
    .csr_priv    (csr_priv),
    .csr_wdata   (csr_wdata),
    .retire      (retire),
    .csr_rdata   (csr_rdata),
    .csr_wval    (csr_wval),
    .csr_illegal (csr_illegal)
  );

  initial clk = 1'b0;
  always #CLK_HALF clk = ~clk;

  // R2 model: the cycle count advances on every edge out of reset
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) m_cycle <= '0;
    else        m_cycle <= m_cycle + W'(1);
  end

  task automatic chk(input string tag, input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic access(input logic en, input logic [1:0] op, input logic [11:0] a,
                        input logic [1:0] pv, input logic [W-1:0] wd, input logic rt,
                        input string tag);
    logic         hit, monly, ro, ill, wr;
    logic [W-1:0] oldv, nv, e_rd, e_wv, ninst;
    logic         ninh;
    @(negedge clk);
    csr_en = en; csr_op = op; csr_addr = a; csr_priv = pv; csr_wdata = wd; retire = rt;
    #1;
    hit = 1'b1; monly = 1'b0; ro = 1'b0; oldv = '0;
    case (a)
      12'hC00, 12'hC01: begin oldv = m_cycle; ro = 1'b1; end
      12'hC02:          begin oldv = m_inst;  ro = 1'b1; end
      12'h320:          begin oldv = {13'd0, m_inh, 2'd0}; monly = 1'b1; end
      12'hB02:          begin oldv = m_inst;  monly = 1'b1; end
      12'hF11, 12'hF12, 12'hF13: begin monly = 1'b1; ro = 1'b1; end
      12'hF14:          begin oldv = W'(HART); monly = 1'b1; ro = 1'b1; end
      default:          hit = 1'b0;
    endcase
    wr  = (op != 2'd0);
    ill = en && (!hit || (monly && pv != 2'd3) || (ro && wr));
    case (op)
      2'd1:    nv = wd;
      2'd2:    nv = oldv | wd;
      2'd3:    nv = oldv & ~wd;
      default: nv = oldv;
    endcase
    if (a == 12'h320) nv = nv & W'(4);
    e_rd = (en && !ill) ? oldv : '0;
    e_wv = (en && !ill && wr) ? nv : '0;
    chk(tag, "rdata", csr_rdata, e_rd);
    chk(tag, "wval", csr_wval, e_wv);
    chk(tag, "illegal", W'(csr_illegal), W'(ill));
    ninst = m_inst;
    ninh  = m_inh;
    if (en && !ill && wr && a == 12'hB02) ninst = nv;
    else if (rt && !m_inh) ninst = m_inst + W'(1);
    if (en && !ill && wr && a == 12'h320) ninh = nv[2];
    @(posedge clk);
    m_inst = ninst;
    m_inh  = ninh;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd4242);
    m_inst = '0; m_inh = 1'b0;
    rst_n = 1'b0; csr_en = 1'b0; csr_op = '0; csr_addr = '0;
    csr_priv = '0; csr_wdata = '0; retire = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "idle rdata", csr_rdata, '0);
    chk("R1", "idle illegal", W'(csr_illegal), '0);
    rst_n = 1'b1;
    // R1 reset values
    access(1, 0, 12'hB02, 3, 0, 0, "R1");
    access(1, 0, 12'h320, 3, 0, 0, "R1");
    access(0, 0, 12'h000, 0, 0, 0, "R1");
    // R2 cycle counter and alias
    repeat (7) access(0, 0, 0, 0, 0, 0, "R2");
    access(1, 0, 12'hC00, 0, 0, 0, "R2");
    access(1, 0, 12'hC01, 1, 0, 0, "R2");
    // R3 retire counting, read via user alias (R10)
    repeat (5) access(0, 0, 0, 0, 0, 1, "R3");
    access(1, 0, 12'hC02, 0, 0, 0, "R3_R10");
    // R6 inhibit masking
    access(1, 1, 12'h320, 3, 16'hFFFF, 0, "R6");
    access(1, 0, 12'h320, 3, 0, 0, "R6");
    // R4 inhibit freezes counting
    repeat (3) access(0, 0, 0, 0, 0, 1, "R4");
    access(1, 0, 12'hB02, 3, 0, 1, "R4");
    access(1, 0, 12'hB02, 3, 0, 0, "R4");
    access(1, 3, 12'h320, 3, 16'h0004, 0, "R7");
    // R5 write beats retire
    access(1, 1, 12'hB02, 3, 16'h1234, 1, "R5");
    access(1, 0, 12'hB02, 3, 0, 0, "R5");
    access(1, 0, 12'hC02, 3, 0, 0, "R5");
    // R3 wrap
    access(1, 1, 12'hB02, 3, 16'hFFFF, 0, "R3");
    access(0, 0, 0, 0, 0, 1, "R3");
    access(1, 0, 12'hB02, 3, 0, 0, "R3");
    // R7 set and clear
    access(1, 2, 12'hB02, 3, 16'h00F0, 0, "R7");
    access(1, 3, 12'hB02, 3, 16'h0030, 0, "R7");
    access(1, 0, 12'hB02, 3, 0, 0, "R7");
    // R8 ID registers
    access(1, 0, 12'hF11, 3, 0, 0, "R8");
    access(1, 0, 12'hF12, 3, 0, 0, "R8");
    access(1, 0, 12'hF13, 3, 0, 0, "R8");
    access(1, 0, 12'hF14, 3, 0, 0, "R8");
    access(1, 1, 12'hF14, 3, 16'h0077, 0, "R8");
    access(1, 2, 12'hF11, 3, 16'h0001, 0, "R8");
    // R9 privilege
    access(1, 0, 12'hF11, 1, 0, 0, "R9");
    access(1, 1, 12'hB02, 0, 16'hAAAA, 0, "R9");
    access(1, 1, 12'h320, 1, 16'h0004, 1, "R9");
    access(1, 0, 12'h320, 3, 0, 0, "R9");
    access(1, 0, 12'hB02, 3, 0, 0, "R9");
    // R10 alias writes
    access(1, 1, 12'hC00, 3, 16'h5555, 0, "R10");
    access(1, 3, 12'hC02, 0, 16'hFFFF, 0, "R10");
    // R11 unimplemented
    access(1, 0, 12'h123, 3, 0, 0, "R11");
    access(1, 1, 12'h7C0, 3, 16'hBEEF, 1, "R11");
    access(1, 0, 12'hB02, 3, 0, 0, "R11");
    // random phase, long enough for the 16-bit cycle count to wrap (R2)
    for (int i = 0; i < 70000; i++) begin
      logic [11:0] a;
      int unsigned k;
      k = $urandom % 11;
      case (k)
        0: a = 12'hC00; 1: a = 12'hC01; 2: a = 12'hC02; 3: a = 12'h320;
        4: a = 12'hB02; 5: a = 12'hF11; 6: a = 12'hF12; 7: a = 12'hF13;
        8: a = 12'hF14; 9: a = 12'hB02;
        default: a = 12'($urandom);
      endcase
      access(($urandom % 8) != 0, 2'($urandom), a, 2'($urandom),
             W'($urandom), 1'($urandom), "R7_rnd");
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule